// File: doc/BRIEF.md
# Flash configuration command sequencer

This block sits on the flash side of a memory bus. It watches bus write cycles, each of which carries a word address and a 16-bit data word. A four-write unlock-and-command sequence loads a 16-bit mode register. The block keeps that register and breaks it into the controls a read engine needs: the read mode (asynchronous or synchronous burst), the number of clocks before the first burst data, the order of the burst beats, the clock edge on which data is launched, and the length of the burst.

A write cycle is one assertion of the active-low chip enable together with the active-low write enable. The block samples both on the rising clock edge. The first cycle in which both are low counts as the write, and that cycle's address and data are the ones used. While an embedded program or erase operation is running, the caller raises a busy flag, and a final register write that arrives during that time is discarded. The bus here is plain control traffic with no back-pressure. The block never stalls a write, so valid/ready handshaking does not apply.

Top module: `flash_cfg_seq`

## Requirements
- R1: After reset the register holds 16'h9C87. This gives asynchronous reads, an access code of 0111 (9 clocks), linear order, launch on the falling edge, and continuous length.
- R2: Four write cycles in a row load the register. They are: data AAh at address 555h, then 55h at 2AAh, then D0h at 555h, then the new 16-bit value at any address. Only the low data byte is compared in the first three writes.
- R3: A write that does not match the expected address or low data byte of the current unlock step returns the sequencer to idle, and the register is not loaded. This includes an abort write of F0h.
- R4: If the busy flag is high during the fourth write, the value is discarded. The sequencer still returns to idle, so a later plain write does not load.
- R5: Bit 15 is the read mode: 1 gives asynchronous reads (`async_read` high), 0 gives synchronous burst reads.
- R6: Bits 13:10 form an access code, and `access_cycles` equals that code plus 2, so codes 0000 to 0111 give 2 to 9 clocks.
- R7: Bit 7 selects the burst order (1 linear, 0 interleaved). Bit 6 selects the launch edge (1 launches burst data on rising clock edges).
- R8: Bits 2:0 give the burst length. 001, 010, 011 and 100 give 8, 16, 32 and 64 bytes. 111 gives continuous with a byte count of 0. Every other code gives a byte count of 0 and continuous low.
- R9: A write that holds both strobes low for several clocks counts as one write cycle.
- R10: After the register loads, the sequencer is idle again, so a further write with no new unlock leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| waddr | input | 19 | Word address of the write |
| wdata | input | 16 | Write data |
| busy | input | 1 | High while an embedded program or erase operation is active |
| cfg_value | output | 16 | Mode register contents |
| async_read | output | 1 | High for asynchronous reads |
| access_cycles | output | 5 | Initial access delay in clocks |
| linear_burst | output | 1 | High for linear order, low for interleaved |
| rising_launch | output | 1 | High when burst data launches on rising edges |
| burst_bytes | output | 7 | Burst length in bytes, 0 when continuous or unsupported |
| burst_continuous | output | 1 | High for continuous burst |

## Verification
Two events can meet in the same clock: the fourth write of an unlock sequence and the busy flag. The bench raises busy before it issues that write and keeps busy high for the whole strobe. It then expects the register to keep its old value. It then drops busy and issues one more plain write, which must also leave the register unchanged. That second write shows the sequencer went back to idle rather than staying armed. A held strobe meeting a sequence step is covered as well: each unlock write is stretched over several clocks, and the register must load exactly once.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_KEY1  = 2'd1,
    SEQ_KEY2  = 2'd2,
    SEQ_ARMED = 2'd3
  } seq_state_t;

  localparam int unsigned KEY_ADDR_A = 32'h555;
  localparam int unsigned KEY_ADDR_B = 32'h2AA;
  localparam logic [7:0]  KEY_DATA_1 = 8'hAA;
  localparam logic [7:0]  KEY_DATA_2 = 8'h55;
  localparam logic [7:0]  KEY_DATA_3 = 8'hD0;
  localparam logic [15:0] CFG_RESET  = 16'h9C87;
endpackage

// File: rtl/flash_wr_strobe.sv
module flash_wr_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_pulse
);
  logic active, active_q;

  assign active = ~ce_n & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active;
  end

  assign wr_pulse = active & ~active_q;

  // A held strobe yields a single write event
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/flash_unlock_fsm.sv
module flash_unlock_fsm
  import flash_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              busy,
  output logic              load_en,
  output seq_state_t        state
);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

  seq_state_t nxt;
  logic [7:0] lo;

  assign lo = data[7:0];

  always_comb begin
    nxt = state;
    if (wr_pulse) begin
      unique case (state)
        SEQ_IDLE:  nxt = (addr == ADDR_A && lo == KEY_DATA_1) ? SEQ_KEY1 : SEQ_IDLE;
        SEQ_KEY1:  nxt = (addr == ADDR_B && lo == KEY_DATA_2) ? SEQ_KEY2 : SEQ_IDLE;
        SEQ_KEY2:  nxt = (addr == ADDR_A && lo == KEY_DATA_3) ? SEQ_ARMED : SEQ_IDLE;
        SEQ_ARMED: nxt = SEQ_IDLE;
        default:   nxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nxt;
  end

  assign load_en = wr_pulse && (state == SEQ_ARMED) && !busy;

  // The armed step is consumed by any write, loaded or not
  assert_idle_after_fourth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && state == SEQ_ARMED) |=> state == SEQ_IDLE);
  // A write off the expected address aborts the sequence
  assert_mismatch_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && state == SEQ_KEY1 && addr != ADDR_B) |=> state == SEQ_IDLE);
endmodule

// File: rtl/flash_cfg_decode.sv
module flash_cfg_decode (
  input  logic [15:0] cfg,
  output logic        async_read,
  output logic [4:0]  access_cycles,
  output logic        linear_burst,
  output logic        rising_launch,
  output logic [6:0]  burst_bytes,
  output logic        burst_continuous
);
  assign async_read    = cfg[15];
  assign access_cycles = {1'b0, cfg[13:10]} + 5'd2;
  assign linear_burst  = cfg[7];
  assign rising_launch = cfg[6];

  always_comb begin
    burst_bytes      = 7'd0;
    burst_continuous = 1'b0;
    unique case (cfg[2:0])
      3'b001:  burst_bytes = 7'd8;
      3'b010:  burst_bytes = 7'd16;
      3'b011:  burst_bytes = 7'd32;
      3'b100:  burst_bytes = 7'd64;
      3'b111:  burst_continuous = 1'b1;
      default: burst_bytes = 7'd0;
    endcase
  end

  always_comb begin
    assert_len_exclusive_R8: assert (!(burst_continuous && burst_bytes != 7'd0));
    assert_len_onehot_R8: assert ($onehot0(burst_bytes));
  end
endmodule

// File: rtl/flash_cfg_seq.sv
module flash_cfg_seq
  import flash_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [15:0]       cfg_value,
  output logic              async_read,
  output logic [4:0]        access_cycles,
  output logic              linear_burst,
  output logic              rising_launch,
  output logic [6:0]        burst_bytes,
  output logic              burst_continuous
);
  logic       wr_pulse, load_en;
  seq_state_t state;
  logic [15:0] cfg_q;

  flash_wr_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .wr_pulse(wr_pulse)
  );

  flash_unlock_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .addr(waddr), .data(wdata),
    .busy(busy), .load_en(load_en), .state(state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= CFG_RESET;
    else if (load_en) cfg_q <= wdata[15:0];
  end

  assign cfg_value = cfg_q;

  flash_cfg_decode u_dec (
    .cfg(cfg_q), .async_read(async_read), .access_cycles(access_cycles),
    .linear_burst(linear_burst), .rising_launch(rising_launch),
    .burst_bytes(burst_bytes), .burst_continuous(burst_continuous)
  );

  // Register changes only on a fourth write after a full unlock
  assert_load_needs_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(state == SEQ_ARMED && wr_pulse));
  // Busy during the fourth write keeps the old value
  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_pulse && state == SEQ_ARMED) |=> $stable(cfg_q));
endmodule

// File: tb/flash_cfg_seq_test.sv
module flash_cfg_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [18:0] waddr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] cfg_value;
  logic        async_read, linear_burst, rising_launch, burst_continuous;
  logic [4:0]  access_cycles;
  logic [6:0]  burst_bytes;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cfg_seq uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .waddr(waddr),
    .wdata(wdata), .busy(busy), .cfg_value(cfg_value), .async_read(async_read),
    .access_cycles(access_cycles), .linear_burst(linear_burst),
    .rising_launch(rising_launch), .burst_bytes(burst_bytes),
    .burst_continuous(burst_continuous)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [15:0] d, input int hold = 1);
    @(negedge clk);
    waddr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; wdata = 16'h0BAD;
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v, input logic [18:0] a = 19'h7_1234);
    wr(19'h555, 16'h00AA);
    wr(19'h2AA, 16'h0055);
    wr(19'h555, 16'h00D0);
    wr(a, v);
  endtask

  task automatic t_reset;
    chk("R1", "cfg", cfg_value, 16'h9C87);
    chk("R1", "async", async_read, 1);
    chk("R1", "cycles", access_cycles, 9);
    chk("R1", "linear", linear_burst, 1);
    chk("R1", "cont", burst_continuous, 1);
    chk("R1", "bytes", burst_bytes, 0);
  endtask

  task automatic t_load;
    load(16'h0CC3);
    chk("R2", "cfg", cfg_value, 16'h0CC3);
    chk("R5", "async", async_read, 0);
    chk("R6", "cycles", access_cycles, 5);
    chk("R7", "linear", linear_burst, 1);
    chk("R7", "rising", rising_launch, 1);
    chk("R8", "bytes", burst_bytes, 32);
    chk("R8", "cont", burst_continuous, 0);
    // upper data bits of key writes are ignored
    wr(19'h555, 16'hFFAA); wr(19'h2AA, 16'h3355); wr(19'h555, 16'h12D0);
    wr(19'h0, 16'h8001);
    chk("R2", "cfg hi-byte keys", cfg_value, 16'h8001);
    chk("R5", "async", async_read, 1);
    chk("R6", "cycles code0", access_cycles, 2);
    chk("R7", "interleaved", linear_burst, 0);
    chk("R7", "falling", rising_launch, 0);
    chk("R8", "bytes 001", burst_bytes, 8);
  endtask

  task automatic t_lengths;
    load(16'h1C02); chk("R8", "bytes 010", burst_bytes, 16);
    chk("R6", "cycles code7", access_cycles, 9);
    load(16'h0004); chk("R8", "bytes 100", burst_bytes, 64);
    load(16'h0007); chk("R8", "cont 111", burst_continuous, 1);
    load(16'h0005); chk("R8", "bytes 101", burst_bytes, 0);
    chk("R8", "cont 101", burst_continuous, 0);
    load(16'h0000); chk("R8", "cont 000", burst_continuous, 0);
  endtask

  task automatic t_mismatch;
    load(16'h1111);
    wr(19'h555, 16'h00AA); wr(19'h2AB, 16'h0055); wr(19'h555, 16'h00D0);
    wr(19'h0, 16'h2222);
    chk("R3", "bad addr", cfg_value, 16'h1111);
    wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0054); wr(19'h555, 16'h00D0);
    wr(19'h0, 16'h3333);
    chk("R3", "bad data", cfg_value, 16'h1111);
    wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055); wr(19'h555, 16'h00F0);
    wr(19'h0, 16'h4444);
    chk("R3", "F0 abort", cfg_value, 16'h1111);
  endtask

  task automatic t_busy;
    load(16'h5555);
    wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055); wr(19'h555, 16'h00D0);
    busy = 1'b1;
    wr(19'h0, 16'h6666);
    busy = 1'b0;
    chk("R4", "busy discard", cfg_value, 16'h5555);
    wr(19'h0, 16'h7777);
    chk("R4", "idle after busy", cfg_value, 16'h5555);
  endtask

  task automatic t_after;
    load(16'h0A0A);
    wr(19'h1, 16'h0B0B);
    chk("R10", "no reload", cfg_value, 16'h0A0A);
  endtask

  task automatic t_hold;
    wr(19'h555, 16'h00AA, 3); wr(19'h2AA, 16'h0055, 4); wr(19'h555, 16'h00D0, 2);
    wr(19'h3, 16'h2C46, 3);
    chk("R9", "held strobes", cfg_value, 16'h2C46);
    wr(19'h3, 16'h0101, 1);
    chk("R9", "one load per strobe", cfg_value, 16'h2C46);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_lengths();
    t_mismatch();
    t_busy();
    t_after();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule